// File: doc/BRIEF.md
# Serial Register Read Receiver

This block performs the read half of a three-wire serial register exchange with a peripheral chip. Once a separate writer has sent the read command, a single start strobe tells this block to take the data line as an input and clock one byte back out of the chip. It drives the serial clock and the active-low chip select itself, and returns the received byte, the trailing parity bit, a parity-error flag and a one-cycle done pulse.

A transfer lasts sixteen serial clock pulses. The first seven are dummy pulses whose data the block discards. The next eight return the byte, most significant bit first. The last one returns the chip's parity bit, chosen so that the nine returned bits hold an odd number of ones. Every clock phase lasts `DIV` system clock cycles, the same phase timing the writer uses. The received results are registered and stay unchanged until the next transfer completes.

Top module: `sreg_read_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, cs_n is 1, sclk is 0, done is 0, and rx_byte, rx_parity and parity_err are 0.
- R2: A start sampled high while idle drives cs_n low from the next cycle. sclk stays low for DIV cycles before its first rising edge.
- R3: A transfer issues exactly 16 sclk pulses. Each pulse is high for DIV cycles and then low for DIV cycles.
- R4: The sdi level during the first 7 pulses (the dummy pulses) has no effect on any output.
- R5: sdi is sampled in the last cycle of the low phase of pulses 8 to 15. These eight samples form rx_byte, with the first sample in bit 7 and the last in bit 0.
- R6: The sdi sample taken after pulse 16 appears on rx_parity. parity_err is 1 exactly when the 9 returned bits contain an even number of ones.
- R7: done is high for exactly one cycle, 33*DIV cycles after the start edge. In that same cycle cs_n returns to 1 and sclk is 0, and rx_byte, rx_parity and parity_err show the new result.
- R8: rx_byte, rx_parity and parity_err change only in a cycle where done is high. They hold their values while idle, even when sdi toggles.
- R9: A start strobe that arrives during a transfer is ignored. The transfer keeps its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read transfer (accepted only while idle) |
| sdi | input | 1 | Sampled serial data line from the chip |
| sclk | output | 1 | Serial clock to the chip |
| cs_n | output | 1 | Active-low chip select |
| rx_byte | output | DATA_W | Received data byte, first bit received in the MSB |
| rx_parity | output | 1 | Parity bit returned by the chip |
| parity_err | output | 1 | High when the returned bits have even parity |
| done | output | 1 | One-cycle pulse marking the end of a transfer |

## Verification
Counting from the clock edge that accepts start, cs_n falls at offset 0. Pulse k (numbered from 0) rises at offset DIV+2kDIV and falls DIV cycles after that. Its data is sampled at offset 3DIV+2kDIV. done, the results and the rise of cs_n all land at offset 33DIV. The bench counts this offset, computes the expected sclk, cs_n and done levels from it, and compares them at every falling clock edge. It changes sdi only at the falling edge that starts each high phase, so each bit is stable across its sampling edge. It also reads the result registers one cycle after done and again across idle stretches with sdi toggling.

// File: rtl/sreg_rd_pkg.sv
package sreg_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_HIGH  = 2'd2,
    ST_LOW   = 2'd3
  } rd_state_t;

  function automatic logic odd_ones(input logic [31:0] v, input int unsigned n);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) acc = acc ^ v[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/sreg_rd_phase_timer.sv
module sreg_rd_phase_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic phase_end
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign phase_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (phase_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: a phase never runs past DIV cycles
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R3: an idle timer restarts from zero
  a_r3_cnt_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);

endmodule

// File: rtl/sreg_rd_shifter.sv
module sreg_rd_shifter #(
  parameter int LEAD_CLKS = 7,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              sdi,
  output logic              last_pulse,
  output logic [DATA_W-1:0] data
);
  localparam int TOTAL = LEAD_CLKS + DATA_W + 1;
  localparam int PW    = $clog2(TOTAL + 1);
  localparam logic [PW-1:0] FIRST_DATA = PW'(LEAD_CLKS);
  localparam logic [PW-1:0] END_DATA   = PW'(LEAD_CLKS + DATA_W);
  localparam logic [PW-1:0] LAST_IDX   = PW'(TOTAL - 1);

  logic [PW-1:0] pcnt;
  logic          in_data;

  assign in_data    = (pcnt >= FIRST_DATA) && (pcnt < END_DATA);
  assign last_pulse = (pcnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pcnt <= '0;
    end else if (sample && !last_pulse) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
    end else if (sample && in_data) begin
      data <= {data[DATA_W-2:0], sdi};
    end
  end

  // R3: sampling never goes past the sixteenth pulse
  a_r3_pulse_bound: assert property (@(posedge clk) disable iff (rst)
    pcnt <= LAST_IDX);

  // R4: dummy pulses leave the assembled data untouched
  a_r4_dummy_ignored: assert property (@(posedge clk) disable iff (rst)
    (sample && pcnt < FIRST_DATA) |=> $stable(data));

endmodule

// File: rtl/sreg_read_rx.sv
module sreg_read_rx #(
  parameter int DIV       = 4,
  parameter int LEAD_CLKS = 7,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sdi,
  output logic              sclk,
  output logic              cs_n,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_parity,
  output logic              parity_err,
  output logic              done
);
  import sreg_rd_pkg::*;

  rd_state_t         state;
  logic              run;
  logic              phase_end;
  logic              sample;
  logic              clear;
  logic              last_pulse;
  logic [DATA_W-1:0] shift_data;

  assign run    = (state != ST_IDLE);
  assign sample = (state == ST_LOW) && phase_end;
  assign clear  = (state == ST_IDLE) && start;

  sreg_rd_phase_timer #(.DIV(DIV)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .phase_end (phase_end)
  );

  sreg_rd_shifter #(.LEAD_CLKS(LEAD_CLKS), .DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .sample     (sample),
    .sdi        (sdi),
    .last_pulse (last_pulse),
    .data       (shift_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sclk       <= 1'b0;
      cs_n       <= 1'b1;
      done       <= 1'b0;
      rx_byte    <= '0;
      rx_parity  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SETUP;
            cs_n  <= 1'b0;
            sclk  <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (phase_end) begin
            state <= ST_HIGH;
            sclk  <= 1'b1;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            state <= ST_LOW;
            sclk  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            if (last_pulse) begin
              state      <= ST_IDLE;
              cs_n       <= 1'b1;
              done       <= 1'b1;
              rx_byte    <= shift_data;
              rx_parity  <= sdi;
              parity_err <= ~(odd_ones(32'(shift_data), DATA_W) ^ sdi);
            end else begin
              state <= ST_HIGH;
              sclk  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the clock only pulses while the chip is selected
  a_r2_sclk_needs_cs: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  // R7: the done cycle deselects the chip with the clock parked low
  a_r7_done_deselect: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !sclk));

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: results change only together with done
  a_r8_hold_results: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(rx_byte) && $stable(rx_parity) && $stable(parity_err)));

  // R6: the error flag reflects even parity across byte and parity bit
  a_r6_parity_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (parity_err == ~(^{rx_byte, rx_parity})));

  // R9: the chip stays selected while a start arrives during a transfer
  a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
    (run && !(state == ST_LOW && phase_end && last_pulse)) |=> !cs_n);

endmodule

// File: tb/tb_sreg_read_rx.sv
module tb_sreg_read_rx;
  localparam int DIV  = 4;
  localparam int NPUL = 16;
  localparam int TEND = (2 * NPUL + 1) * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       sdi = 1'b0;
  logic       sclk, cs_n, rx_parity, parity_err, done;
  logic [7:0] rx_byte;

  int tests = 0;
  int fails = 0;

  logic [7:0] held_byte = 8'h00;
  logic       held_par  = 1'b0;
  logic       held_err  = 1'b0;

  sreg_read_rx #(.DIV(DIV)) dut (
    .clk(clk), .rst(rst), .start(start), .sdi(sdi),
    .sclk(sclk), .cs_n(cs_n), .rx_byte(rx_byte),
    .rx_parity(rx_parity), .parity_err(parity_err), .done(done)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_held(input string req);
    check(rx_byte == held_byte, req, rx_byte, held_byte);
    check({rx_parity, parity_err} == {held_par, held_err}, req,
          {rx_parity, parity_err}, {held_par, held_err});
  endtask

  // One transfer; the expected waveform is derived from the offset t since the start edge
  task automatic xfer(input logic [7:0] bv, input logic pv, input bit poke);
    logic exp_err;
    exp_err = ~(^{bv, pv});
    @(negedge clk);
    check_held("R8 held before start");
    start = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= TEND + 1; t++) begin
      logic es, ec, ed;
      @(negedge clk);
      start = 1'b0;
      ec = (t >= TEND);
      es = (t < TEND) && (t >= DIV) && (((t - DIV) % (2 * DIV)) < DIV);
      ed = (t == TEND);
      check({sclk, cs_n, done} == {es, ec, ed}, "R2 R3 R7 R9 waveform",
            {sclk, cs_n, done}, {es, ec, ed});
      if (t < TEND) check_held("R8 held during transfer");
      if (t == TEND) begin
        check(rx_byte == bv, "R5 byte", rx_byte, bv);
        check(rx_parity == pv, "R6 parity bit", rx_parity, pv);
        check(parity_err == exp_err, "R6 parity error", parity_err, exp_err);
        held_byte = bv; held_par = pv; held_err = exp_err;
      end
      if (t == TEND + 1) check_held("R7 R8 held after done");
      if (poke && t == 10 * DIV) start = 1'b1;  // R9 busy start
      if (t >= DIV && ((t - DIV) % (2 * DIV)) == 0) begin
        int k;
        k = (t - DIV) / (2 * DIV);
        if (k < 7) sdi = 1'($urandom);          // R4 dummy noise
        else if (k < 15) sdi = bv[14 - k];
        else if (k < NPUL) sdi = pv;
      end
    end
  endtask

  task automatic idle_noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdi = 1'($urandom);
      check({sclk, cs_n, done} == 3'b010, "R8 idle outputs", {sclk, cs_n, done}, 3'b010);
      check_held("R8 idle hold");
    end
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({sclk, cs_n, done, rx_parity, parity_err, rx_byte} == {5'b01000, 8'h00},
          "R1 in reset", {sclk, cs_n, done, rx_parity, parity_err, rx_byte}, {5'b01000, 8'h00});
    rst = 1'b0;
    @(negedge clk);
    check({sclk, cs_n, done, rx_parity, parity_err, rx_byte} == {5'b01000, 8'h00},
          "R1 after reset", {sclk, cs_n, done, rx_parity, parity_err, rx_byte}, {5'b01000, 8'h00});
    xfer(8'hA5, 1'b1, 1'b0);
    idle_noise(9);
    xfer(8'h3C, 1'b0, 1'b0);   // even ones: error expected
    xfer(8'h00, 1'b1, 1'b0);
    idle_noise(5);
    xfer(8'hFF, 1'b0, 1'b1);   // even ones, plus busy start
    xfer(8'h81, 1'b1, 1'b1);
    xfer(8'h01, 1'b0, 1'b0);
    idle_noise(12);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule